// File: doc/BRIEF.md
# Codec Frame Generator with On-Request Mid-Frame Sync

This block is the bus master of a synchronous serial link to a codec. It divides the system clock down to a bit clock and produces a frame-sync pulse. It shifts out one audio word per frame and captures one audio word from the receive line. Every frame lasts 128 bit periods. An audio slot of 16 bits sits at the start of each frame, sent and received with the most significant bit first.

The least significant bit of the outgoing audio word requests a control exchange. When that bit is 1, a second sync pulse is sent at bit 64. A 16-bit control word is then exchanged in both directions in the slot that follows. When the bit is 0, the second half of the frame stays idle. The control receive word keeps its old value in that case.

Transmit words arrive as parallel inputs and are taken in at the start of each frame. Received words are presented as parallel outputs, each with a one-cycle strobe.

Top module: `sfs_top`

## Requirements
- R1: The bit clock `sck` has a period of `CLK_DIV` system cycles. It is high for `CLK_DIV/2` cycles and low for `CLK_DIV/2` cycles.
- R2: Reset is synchronous and active high. While it is applied, every output is 0.
- R3: Bit indices within a frame run from 0 to 127, and each index begins at a falling edge of `sck`. `fs` is high for exactly bit index 0 of every frame.
- R4: Bits 0 to 15 of the frame carry the latched audio word, MSB first, at bit index = 15 − bit position. `txd` and `fs` change only in the system cycle in which `sck` falls.
- R5: `fs` is also high for bit index 64, and only for that index, when bit 0 of the audio word latched for the current frame is 1. It is low at bit 64 otherwise.
- R6: After a secondary sync, bits 64 to 79 carry the latched control word on `txd`, MSB first.
- R7: `rxd` is sampled when `sck` rises. Bits 0 to 15 form `rxAudio`, MSB first. `rxAudioValid` is a one-cycle pulse in the cycle in which `sck` rises for bit 15.
- R8: After a secondary sync, bits 64 to 79 of `rxd` form `rxCtrl`, MSB first. `rxCtrlValid` pulses for one cycle when `sck` rises for bit 79.
- R9: In a frame without a secondary sync, `txd` is 0 from bit 16 to bit 127, `rxCtrlValid` stays low and `rxCtrl` keeps its value. `txd` is also 0 from bit 80 to bit 127 in frames that have one.
- R10: `audioTx` and `ctrlTx` are captured at the falling edge of `sck` that begins bit 0. Changes to them later in the frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| audioTx | input | WORD_BITS | Audio word to send; bit 0 requests the control exchange |
| ctrlTx | input | WORD_BITS | Control word to send after a secondary sync |
| rxd | input | 1 | Serial receive data |
| sck | output | 1 | Bit clock |
| fs | output | 1 | Frame sync (normal and secondary) |
| txd | output | 1 | Serial transmit data |
| rxAudio | output | WORD_BITS | Last received audio word |
| rxAudioValid | output | 1 | One-cycle strobe for a new `rxAudio` |
| rxCtrl | output | WORD_BITS | Last received control word |
| rxCtrlValid | output | 1 | One-cycle strobe for a new `rxCtrl` |

## Verification
The bench builds the block with its defaults: `CLK_DIV` = 4, 128-bit frames and 16-bit slots. This makes one frame 512 cycles long, so twelve full frames fit easily in a run.

At these sizes every bit index of every frame is checked. Every bit position of both words is exercised through walking patterns. The run covers frames with and without a control request, and input words that change halfway through a slot. It also covers idle bits driven with a toggling `rxd`.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  // Strobes issued by the sequencer to the datapath, one system cycle wide.
  typedef struct packed {
    logic fallTick;     // sck falls at this edge, next bit begins
    logic riseTick;     // sck rises at this edge, rxd is sampled
    logic loadAudio;    // next bit is bit 0: take in words, start audio slot
    logic loadCtrl;     // next bit is the secondary sync point, start control slot
    logic rxShiftEn;    // current bit lies in an active receive slot
    logic rxAudioDone;  // last audio bit is being sampled
    logic rxCtrlDone;   // last control bit is being sampled
  } sfsStrobes_t;
endpackage

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int FRAME_BITS = 128,
  parameter int WORD_BITS  = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        audioLsb,
  output logic        sck,
  output sfsStrobes_t strobes
);
  localparam int DIV_W     = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W     = $clog2(FRAME_BITS);
  localparam int HALF_BITS = FRAME_BITS / 2;

  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [BIT_W-1:0] nextBit;
  logic             secReq;
  logic             fallTick;
  logic             riseTick;
  logic             inAudio;
  logic             inCtrl;

  assign fallTick = (divCnt == DIV_W'(CLK_DIV - 1));
  assign riseTick = (divCnt == DIV_W'(CLK_DIV / 2 - 1));
  assign nextBit  = (bitCnt == BIT_W'(FRAME_BITS - 1)) ? '0 : bitCnt + 1'b1;
  assign inAudio  = (bitCnt < BIT_W'(WORD_BITS));
  assign inCtrl   = secReq && (bitCnt >= BIT_W'(HALF_BITS))
                           && (bitCnt < BIT_W'(HALF_BITS + WORD_BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
      bitCnt <= BIT_W'(FRAME_BITS - 1);
      sck    <= 1'b0;
      secReq <= 1'b0;
    end else begin
      divCnt <= fallTick ? '0 : divCnt + 1'b1;
      if (riseTick) sck <= 1'b1;
      if (fallTick) begin
        sck    <= 1'b0;
        bitCnt <= nextBit;
        if (nextBit == '0) secReq <= audioLsb;
      end
    end
  end

  always_comb begin
    strobes             = '0;
    strobes.fallTick    = fallTick;
    strobes.riseTick    = riseTick;
    strobes.loadAudio   = fallTick && (nextBit == '0);
    strobes.loadCtrl    = fallTick && secReq && (nextBit == BIT_W'(HALF_BITS));
    strobes.rxShiftEn   = riseTick && (inAudio || inCtrl);
    strobes.rxAudioDone = riseTick && (bitCnt == BIT_W'(WORD_BITS - 1));
    strobes.rxCtrlDone  = riseTick && secReq
                          && (bitCnt == BIT_W'(HALF_BITS + WORD_BITS - 1));
  end
endmodule

// File: rtl/sfs_datapath.sv
module sfs_datapath
  import sfs_pkg::*;
#(
  parameter int WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  sfsStrobes_t          strobes,
  input  logic [WORD_BITS-1:0] audioTx,
  input  logic [WORD_BITS-1:0] ctrlTx,
  input  logic                 rxd,
  output logic                 fs,
  output logic                 txd,
  output logic [WORD_BITS-1:0] rxAudio,
  output logic                 rxAudioValid,
  output logic [WORD_BITS-1:0] rxCtrl,
  output logic                 rxCtrlValid
);
  logic [WORD_BITS-1:0] ctrlHold;
  logic [WORD_BITS-1:0] txShift;
  logic [WORD_BITS-1:0] rxShift;
  logic [WORD_BITS-1:0] rxWord;

  assign txd    = txShift[WORD_BITS-1];
  assign rxWord = {rxShift[WORD_BITS-2:0], rxd};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlHold <= '0;
      txShift  <= '0;
      fs       <= 1'b0;
    end else if (strobes.fallTick) begin
      fs <= strobes.loadAudio || strobes.loadCtrl;
      if (strobes.loadAudio) begin
        txShift  <= audioTx;
        ctrlHold <= ctrlTx;
      end else if (strobes.loadCtrl) begin
        txShift <= ctrlHold;
      end else begin
        txShift <= {txShift[WORD_BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxShift      <= '0;
      rxAudio      <= '0;
      rxCtrl       <= '0;
      rxAudioValid <= 1'b0;
      rxCtrlValid  <= 1'b0;
    end else begin
      rxAudioValid <= strobes.rxAudioDone;
      rxCtrlValid  <= strobes.rxCtrlDone;
      if (strobes.rxShiftEn)   rxShift <= rxWord;
      if (strobes.rxAudioDone) rxAudio <= rxWord;
      if (strobes.rxCtrlDone)  rxCtrl  <= rxWord;
    end
  end
endmodule

// File: rtl/sfs_top.sv
module sfs_top
  import sfs_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int FRAME_BITS = 128,
  parameter int WORD_BITS  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WORD_BITS-1:0] audioTx,
  input  logic [WORD_BITS-1:0] ctrlTx,
  input  logic                 rxd,
  output logic                 sck,
  output logic                 fs,
  output logic                 txd,
  output logic [WORD_BITS-1:0] rxAudio,
  output logic                 rxAudioValid,
  output logic [WORD_BITS-1:0] rxCtrl,
  output logic                 rxCtrlValid
);
  sfsStrobes_t strobes;

  sfs_ctrl #(
    .CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS), .WORD_BITS(WORD_BITS)
  ) uCtrl (
    .clk(clk), .rst(rst), .audioLsb(audioTx[0]), .sck(sck), .strobes(strobes)
  );

  sfs_datapath #(.WORD_BITS(WORD_BITS)) uData (
    .clk(clk), .rst(rst), .strobes(strobes),
    .audioTx(audioTx), .ctrlTx(ctrlTx), .rxd(rxd),
    .fs(fs), .txd(txd),
    .rxAudio(rxAudio), .rxAudioValid(rxAudioValid),
    .rxCtrl(rxCtrl), .rxCtrlValid(rxCtrlValid)
  );
endmodule

// File: rtl/sfs_chk.sv
module sfs_chk #(
  parameter int CLK_DIV   = 4,
  parameter int WORD_BITS = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 sck,
  input logic                 fs,
  input logic                 txd,
  input logic                 rxAudioValid,
  input logic [WORD_BITS-1:0] rxCtrl,
  input logic                 rxCtrlValid
);
  localparam int RUN_W = $clog2(CLK_DIV) + 2;

  logic [RUN_W-1:0] runLen;
  logic             sckQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      runLen <= '0;
      sckQ   <= 1'b0;
    end else begin
      sckQ   <= sck;
      runLen <= (sck != sckQ) ? RUN_W'(1) : runLen + 1'b1;
    end
  end

  // R1
  sck_phase_len_chk: assert property (@(posedge clk) disable iff (rst)
    runLen <= RUN_W'(CLK_DIV / 2));

  // R4
  tx_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ((fs != $past(fs)) || (txd != $past(txd))) |-> ($past(sck) && !sck));

  // R7
  audio_strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rxAudioValid |=> !rxAudioValid);

  // R7
  audio_strobe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rxAudioValid |-> (sck && !$past(sck)));

  // R8
  ctrl_strobe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rxCtrlValid |-> (sck && !$past(sck)));

  // R9
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rxCtrlValid |-> $stable(rxCtrl));
endmodule

bind sfs_top sfs_chk #(.CLK_DIV(CLK_DIV), .WORD_BITS(WORD_BITS)) uChk (
  .clk(clk), .rst(rst), .sck(sck), .fs(fs), .txd(txd),
  .rxAudioValid(rxAudioValid), .rxCtrl(rxCtrl), .rxCtrlValid(rxCtrlValid)
);

// File: tb/tb_sfs_top.sv
module tb_sfs_top;
  localparam int CLK_DIV = 4;
  localparam int FRAME   = 128;
  localparam int HALF    = FRAME / 2;
  localparam int W       = 16;
  localparam int NFR     = 12;
  localparam int LIMIT   = 200000;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] audioTx, ctrlTx;
  logic         rxd;
  logic         sck, fs, txd, rxAudioValid, rxCtrlValid;
  logic [W-1:0] rxAudio, rxCtrl;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sfs_top #(.CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME), .WORD_BITS(W)) dut (
    .clk(clk), .rst(rst), .audioTx(audioTx), .ctrlTx(ctrlTx), .rxd(rxd),
    .sck(sck), .fs(fs), .txd(txd), .rxAudio(rxAudio),
    .rxAudioValid(rxAudioValid), .rxCtrl(rxCtrl), .rxCtrlValid(rxCtrlValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] audioPat(input int f);
    logic [W-1:0] v;
    v    = (16'h0001 << (f % W)) ^ 16'hC3A4 ^ W'(f * 16'h0111);
    v[0] = (f % 3) != 1;
    return v;
  endfunction

  function automatic logic [W-1:0] ctrlPat(input int f);
    return ~(16'h8000 >> (f % W)) ^ W'(f * 16'h0B35);
  endfunction

  function automatic logic [W-1:0] rxAPat(input int f);
    return 16'hF00F ^ (16'h0001 << ((f + 5) % W));
  endfunction

  function automatic logic [W-1:0] rxCPat(input int f);
    return 16'h3C5A ^ W'(f * 16'h1357);
  endfunction

  initial begin
    int cyc = 0, lastRise = -1, lastFall = -1;
    int idx = FRAME - 1, frameNo = 0;
    bit sec = 0, sckPrev = 0;
    logic [W-1:0] expA = '0, expC = '0, patA = '0, patC = '0, lastRxC = '0;
    rst = 1'b1; rxd = 1'b0;
    audioTx = audioPat(1); ctrlTx = ctrlPat(1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: every output low during reset
    check({sck, fs, txd, rxAudioValid, rxCtrlValid} == 5'b0, "R2 ctl outputs", 
          int'({sck, fs, txd, rxAudioValid, rxCtrlValid}), 0);
    check(rxAudio == '0 && rxCtrl == '0, "R2 word outputs", int'({rxAudio, rxCtrl}), 0);
    rst = 1'b0;
    while (frameNo <= NFR) begin
      bit rise, fall;
      @(negedge clk);
      cyc++;
      if (cyc > LIMIT) begin
        check(0, "watchdog", cyc, LIMIT);
        break;
      end
      rise = sck && !sckPrev;
      fall = !sck && sckPrev;
      sckPrev = sck;
      if (fall) begin
        // R1: high phase
        if (lastRise >= 0) check(cyc - lastRise == CLK_DIV / 2, "R1 high time", cyc - lastRise, CLK_DIV / 2);
        lastFall = cyc;
        idx = (idx + 1) % FRAME;
        if (idx == 0) begin
          frameNo++;
          expA = audioTx; expC = ctrlTx; sec = audioTx[0];
          patA = rxAPat(frameNo); patC = rxCPat(frameNo);
        end
        // R10: change inputs in the middle of the audio slot
        if (idx == 8) begin
          audioTx = audioPat(frameNo + 1);
          ctrlTx  = ctrlPat(frameNo + 1);
        end
        if (idx < W) rxd = patA[W-1-idx];
        else if (sec && idx >= HALF && idx < HALF + W) rxd = patC[W-1-(idx-HALF)];
        else rxd = idx[0];
      end
      if (rise) begin
        bit expFs, expTx;
        // R1: period and low phase
        if (lastRise >= 0) check(cyc - lastRise == CLK_DIV, "R1 period", cyc - lastRise, CLK_DIV);
        if (lastFall >= 0) check(cyc - lastFall == CLK_DIV / 2, "R1 low time", cyc - lastFall, CLK_DIV / 2);
        lastRise = cyc;
        expFs = (frameNo > 0) && ((idx == 0) || (sec && idx == HALF));
        if (idx == HALF) check(fs == expFs, "R5 secondary sync", fs, expFs);
        else             check(fs == expFs, "R3 frame sync", fs, expFs);
        if (frameNo > 0 && idx < W) begin
          expTx = expA[W-1-idx];
          check(txd == expTx, "R4/R10 audio bit", txd, expTx);
        end else if (sec && idx >= HALF && idx < HALF + W) begin
          expTx = expC[W-1-(idx-HALF)];
          check(txd == expTx, "R6/R10 control bit", txd, expTx);
        end else begin
          check(txd == 1'b0, "R9 idle txd", txd, 0);
        end
        if (idx == FRAME - 1 && frameNo > 0 && !sec)
          check(rxCtrl == lastRxC, "R9 rxCtrl held", rxCtrl, lastRxC);
      end
      begin
        bit expAV, expCV;
        expAV = rise && frameNo > 0 && idx == W - 1;
        expCV = rise && sec && idx == HALF + W - 1;
        if (rxAudioValid || expAV) begin
          check(rxAudioValid == expAV, "R7 audio strobe", rxAudioValid, expAV);
          check(rxAudio == patA, "R7 audio word", rxAudio, patA);
        end
        if (rxCtrlValid || expCV) begin
          check(rxCtrlValid == expCV, "R8 control strobe", rxCtrlValid, expCV);
          check(rxCtrl == patC, "R8 control word", rxCtrl, patC);
          lastRxC = rxCtrl;
        end
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule